// File: doc/BRIEF.md
# Register Command Buffer Executor

This block walks a list of 32-bit instruction words held in a memory, starting at a head index and stopping when its read index reaches a tail index. Each instruction is at least two words long and begins on an even word index. The block decodes each instruction and turns it into one or more register writes on a simple write bus that uses a valid/ready handshake.

Two instruction kinds are understood. A single write carries its data, byte enables and register offset in two words. An indexed write begins with a word count, then an opcode/offset word, then that many data words. All of those data words go to the same register offset, which suits auto-incrementing register ports such as colour tables. When the total length of an indexed instruction is odd, one pad word follows it so that the next instruction lands on an even index. The executor steps over that pad word without fetching it.

An unknown opcode stops the walk and raises a sticky error. A finished walk gives a one-cycle done pulse.

Top module: `cmdbuf_exec`

## Requirements
- R1: After reset, busy, done, err, wr_valid and mem_rd are all low.
- R2: An instruction whose second word has bits 31:24 equal to 0x01 produces exactly one write. Its data is the first word, its byte enables are bits 23:20 of the second word, and its address is bits 19:0 of the second word.
- R3: An instruction whose second word has bits 31:24 equal to 0x09 takes its count N from the low ADDR_W bits of its first word. It produces N writes, in memory order, of the N following words. All of them go to the offset in bits 19:0 of the second word, with byte enables 4'hF.
- R4: The instruction after an indexed one starts at index head+2+N, rounded up to the next even index. When N is odd, one pad word is skipped and never written.
- R5: An indexed instruction with N = 0 produces no writes, and the next instruction starts two words later.
- R6: When the read index equals the tail index, done is high for exactly one cycle and busy falls. A start with head equal to tail gives done with no writes.
- R7: Any other opcode sets err, and err holds until reset. Execution stops with no done and no further writes. Start pulses are ignored while err is set.
- R8: While wr_valid is high and wr_ready is low, wr_valid, wr_addr, wr_data and wr_be stay unchanged. No new write is offered before the current one is accepted.
- R9: A start pulse while busy is ignored.
- R10: Read data is taken on the cycle after mem_rd is asserted. mem_rd is only asserted while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk from head to tail |
| head | input | ADDR_W | First instruction word index |
| tail | input | ADDR_W | Index at which the walk ends |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| err | output | 1 | Sticky unknown-opcode flag |
| mem_rd | output | 1 | Read request to the buffer memory |
| mem_addr | output | ADDR_W | Word index being read |
| mem_rdata | input | 32 | Read data, valid one cycle after mem_rd |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Register write accepted |
| wr_addr | output | 20 | Register offset |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Byte enables |

## Verification
Two things can happen in the same cycle: the bus accepts an indexed write, and the memory read for the next data word is issued. If the read moved ahead or fell behind by one word, the logged writes would be shifted or repeated.

The bench provokes this case in two ways. Some runs hold wr_ready high, so the handshake and the next read always coincide. Other runs drive wr_ready from a pseudo-random sequence, so acceptance falls on varied cycles.

Each run is judged by comparing the full list of accepted writes against the expected order, count, offsets and byte enables. A monitor also confirms that an offered write never changes before it is taken.

// File: rtl/cmdbuf_pkg.sv
// Shared opcodes, field positions and controller states for the command
// buffer executor. Assumes 32-bit instruction words.
package cmdbuf_pkg;
    localparam int WORD_W   = 32;
    localparam int OFF_W    = 20;
    localparam int BE_W     = 4;
    localparam int OP_LSB   = 24;
    localparam int BE_LSB   = 20;
    localparam logic [7:0] OP_SINGLE  = 8'h01;
    localparam logic [7:0] OP_INDEXED = 8'h09;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_HDR0,
        S_HDR1,
        S_DATA,
        S_WAIT
    } exec_state_t;
endpackage

// File: rtl/cmdbuf_decode.sv
// Splits the opcode/offset word of an instruction into its fields and
// classifies the opcode. Purely combinational; assumes the word is valid.
module cmdbuf_decode
    import cmdbuf_pkg::*;
(
    input  logic [WORD_W-1:0] op_word,
    output logic              is_single,
    output logic              is_indexed,
    output logic              is_bad,
    output logic [OFF_W-1:0]  offset,
    output logic [BE_W-1:0]   byte_en
);
    logic [7:0] opcode;

    // Field extraction and opcode classification.
    always_comb begin
        opcode     = op_word[OP_LSB +: 8];
        offset     = op_word[OFF_W-1:0];
        byte_en    = op_word[BE_LSB +: BE_W];
        is_single  = (opcode == OP_SINGLE);
        is_indexed = (opcode == OP_INDEXED);
        is_bad     = !is_single && !is_indexed;
    end
endmodule

// File: rtl/cmdbuf_wr_port.sv
// Holds one outgoing register write until the bus accepts it. A load while
// a write is pending is not expected; the controller never issues one.
module cmdbuf_wr_port
    import cmdbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [OFF_W-1:0]  ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [BE_W-1:0]   ld_be,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [OFF_W-1:0]  wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [BE_W-1:0]   wr_be,
    output logic              accept
);
    assign accept = wr_valid && wr_ready;

    // Valid flag: raised on load, dropped on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_valid <= 1'b0;
        else if (load)
            wr_valid <= 1'b1;
        else if (accept)
            wr_valid <= 1'b0;
    end

    // Payload: captured on load, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
            wr_be   <= '0;
        end else if (load) begin
            wr_addr <= ld_addr;
            wr_data <= ld_data;
            wr_be   <= ld_be;
        end
    end
endmodule

// File: rtl/cmdbuf_exec.sv
// Walks a command buffer from head to tail, decoding single and indexed
// register-write instructions onto a valid/ready write bus. Assumes a
// one-cycle read latency memory and an even tail on an instruction boundary.
module cmdbuf_exec
    import cmdbuf_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] head,
    input  logic [ADDR_W-1:0] tail,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [19:0]       wr_addr,
    output logic [31:0]       wr_data,
    output logic [3:0]        wr_be
);
    localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

    exec_state_t       st;
    logic [ADDR_W-1:0] ptr, tail_q, rp, nxt, rem, cnt_t;
    logic [WORD_W-1:0] w0;
    logic [OFF_W-1:0]  off_q;
    logic              dec_single, dec_idx, dec_bad;
    logic [OFF_W-1:0]  dec_off;
    logic [BE_W-1:0]   dec_be;
    logic              load, accept;
    logic [OFF_W-1:0]  ld_addr;
    logic [WORD_W-1:0] ld_data;
    logic [BE_W-1:0]   ld_be;

    assign busy  = (st != S_IDLE);
    assign cnt_t = w0[ADDR_W-1:0];

    cmdbuf_decode u_dec (
        .op_word    (mem_rdata),
        .is_single  (dec_single),
        .is_indexed (dec_idx),
        .is_bad     (dec_bad),
        .offset     (dec_off),
        .byte_en    (dec_be)
    );

    // Memory read request and index for each fetch point.
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = ptr;
        case (st)
            S_CHECK: mem_rd = (ptr != tail_q);
            S_HDR0:  begin mem_rd = 1'b1; mem_addr = ptr + 1'b1; end
            S_HDR1:  begin mem_rd = dec_idx && (cnt_t != '0); mem_addr = ptr + TWO; end
            S_WAIT:  begin mem_rd = accept && (rem != '0); mem_addr = rp; end
            default: ;
        endcase
    end

    // Write payload selection: header-sourced single or streamed indexed data.
    always_comb begin
        load    = (st == S_HDR1 && dec_single) || (st == S_DATA);
        ld_addr = (st == S_DATA) ? off_q : dec_off;
        ld_data = (st == S_DATA) ? mem_rdata : w0;
        ld_be   = (st == S_DATA) ? {BE_W{1'b1}} : dec_be;
    end

    cmdbuf_wr_port u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .ld_be    (ld_be),
        .wr_ready (wr_ready),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_be    (wr_be),
        .accept   (accept)
    );

    // Instruction sequencing, pointer update, done and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            ptr    <= '0;
            tail_q <= '0;
            rp     <= '0;
            nxt    <= '0;
            rem    <= '0;
            w0     <= '0;
            off_q  <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: if (start && !err) begin
                    ptr    <= head;
                    tail_q <= tail;
                    st     <= S_CHECK;
                end
                S_CHECK: if (ptr == tail_q) begin
                    done <= 1'b1;
                    st   <= S_IDLE;
                end else begin
                    st <= S_HDR0;
                end
                S_HDR0: begin
                    w0 <= mem_rdata;
                    st <= S_HDR1;
                end
                S_HDR1: begin
                    off_q <= dec_off;
                    if (dec_single) begin
                        nxt <= ptr + TWO;
                        rem <= '0;
                        st  <= S_WAIT;
                    end else if (dec_idx && cnt_t == '0) begin
                        ptr <= ptr + TWO;
                        st  <= S_CHECK;
                    end else if (dec_idx) begin
                        rem <= cnt_t;
                        rp  <= ptr + TWO;
                        nxt <= ptr + TWO + cnt_t + ADDR_W'(cnt_t[0]);
                        st  <= S_DATA;
                    end else begin
                        err <= 1'b1;
                        st  <= S_IDLE;
                    end
                end
                S_DATA: begin
                    rp  <= rp + 1'b1;
                    rem <= rem - 1'b1;
                    st  <= S_WAIT;
                end
                S_WAIT: if (accept) begin
                    if (rem == '0) begin
                        ptr <= nxt;
                        st  <= S_CHECK;
                    end else begin
                        st <= S_DATA;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    logic unused_dec;
    assign unused_dec = dec_bad;
endmodule

// File: rtl/cmdbuf_exec_chk.sv
// Temporal checks on the executor's ports, bound into every instance.
module cmdbuf_exec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        mem_rd,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [19:0] wr_addr,
    input logic [31:0] wr_data,
    input logic [3:0]  wr_be
);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be));
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    p_err_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy && !wr_valid && !done);
    p_rd_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy);
endmodule

bind cmdbuf_exec cmdbuf_exec_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .mem_rd   (mem_rd),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_be    (wr_be)
);

// File: tb/cmdbuf_exec_test.sv
module cmdbuf_exec_test;
    localparam int ADDR_W = 8;
    localparam int NV = 6;
    localparam int TBL_N [NV]     = '{0, 1, 2, 3, 4, 7};
    localparam bit TBL_STALL [NV] = '{0, 0, 1, 0, 1, 1};

    logic clk = 0, rst_n = 0, start = 0;
    logic [ADDR_W-1:0] head = 0, tail = 0;
    logic busy, done, err, mem_rd, wr_valid, wr_ready;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0] mem_rdata, wr_data;
    logic [19:0] wr_addr;
    logic [3:0]  wr_be;

    logic [31:0] mem [0:255];
    logic [19:0] log_addr [0:63];
    logic [31:0] log_data [0:63];
    logic [3:0]  log_be   [0:63];
    int log_n = 0, done_cnt = 0, hold_err = 0;
    int tests = 0, fails = 0;
    logic stall_en = 0, prev_pend = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [19:0] prev_addr;
    logic [31:0] prev_data;
    logic [3:0]  prev_be;

    always #10 clk = ~clk;

    cmdbuf_exec #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .head(head), .tail(tail),
        .busy(busy), .done(done), .err(err), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
    );

    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

    always @(negedge clk) begin
        lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wr_ready <= stall_en ? lfsr[0] : 1'b1;
    end

    always @(posedge clk) if (rst_n) begin
        if (wr_valid && wr_ready && log_n < 64) begin
            log_addr[log_n] <= wr_addr;
            log_data[log_n] <= wr_data;
            log_be[log_n]   <= wr_be;
            log_n <= log_n + 1;
        end
        if (prev_pend && (!wr_valid || wr_addr != prev_addr || wr_data != prev_data || wr_be != prev_be))
            hold_err <= hold_err + 1;
        prev_pend <= wr_valid && !wr_ready;
        prev_addr <= wr_addr; prev_data <= wr_data; prev_be <= wr_be;
        if (done) done_cnt <= done_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [ADDR_W-1:0] h, input logic [ADDR_W-1:0] t);
        int guard = 0;
        log_n = 0; done_cnt = 0;
        @(negedge clk); start = 1; head = h; tail = t;
        @(negedge clk); start = 0;
        while (busy && guard < 3000) begin @(negedge clk); guard++; end
        chk(guard < 3000, "R6", "run finished", 32'(guard), 32'd3000);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] op_word(input logic [7:0] op, input logic [3:0] be,
                                            input logic [19:0] off);
        return {op, be, off};
    endfunction

    initial begin
        #(20ns * 150000);
        tests++; fails++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hEEEE_0000 | 32'(i);
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !wr_valid && !mem_rd, "R1", "reset outputs",
            {27'd0, busy, done, err, wr_valid, mem_rd}, 32'd0);
        rst_n = 1;
        @(negedge clk);

        // Table walk: indexed instruction of N words, then a single write.
        for (int k = 0; k < NV; k++) begin
            int n = TBL_N[k];
            int b = k * 20;
            int p;
            stall_en = TBL_STALL[k];
            mem[b]   = 32'(n);
            mem[b+1] = op_word(8'h09, 4'h0, 20'h0A000 + 20'(n));
            for (int i = 0; i < n; i++) mem[b+2+i] = 32'hD000_0000 | (32'(n) << 8) | 32'(i);
            if (n % 2 == 1) mem[b+2+n] = 32'h0;
            p = b + 2 + n + (n % 2);
            mem[p]   = 32'h5A5A_0000 + 32'(n);
            mem[p+1] = op_word(8'h01, 4'b0110, 20'h12345);
            run(ADDR_W'(b), ADDR_W'(p + 2));
            chk(log_n == n + 1, n == 0 ? "R5" : "R3", "write count", 32'(log_n), 32'(n + 1));
            for (int i = 0; i < n && i < log_n; i++)
                chk(log_addr[i] == 20'h0A000 + 20'(n) && log_be[i] == 4'hF &&
                    log_data[i] == (32'hD000_0000 | (32'(n) << 8) | 32'(i)),
                    "R3", "indexed write", log_data[i], 32'hD000_0000 | (32'(n) << 8) | 32'(i));
            if (log_n == n + 1)
                chk(log_addr[n] == 20'h12345 && log_be[n] == 4'b0110 &&
                    log_data[n] == 32'h5A5A_0000 + 32'(n), "R4", "single after pad (R2)",
                    log_data[n], 32'h5A5A_0000 + 32'(n));
            chk(done_cnt == 1, "R6", "done pulses", 32'(done_cnt), 32'd1);
        end

        // Empty walk.
        stall_en = 0;
        run(8'd130, 8'd130);
        chk(done_cnt == 1 && log_n == 0, "R6", "empty walk done/no writes",
            {16'(done_cnt), 16'(log_n)}, {16'd1, 16'd0});

        // Start while busy is ignored.
        stall_en = 1;
        mem[140] = 32'd7;
        mem[141] = op_word(8'h09, 4'h0, 20'h0BEEF);
        for (int i = 0; i < 7; i++) mem[142+i] = 32'hC0DE_0000 + 32'(i);
        mem[149] = 32'h0;
        mem[200] = 32'hBAD0_BAD0;
        mem[201] = op_word(8'h01, 4'hF, 20'h0DEAD);
        log_n = 0; done_cnt = 0;
        @(negedge clk); start = 1; head = 8'd140; tail = 8'd150;
        @(negedge clk); start = 0;
        repeat (3) @(negedge clk);
        start = 1; head = 8'd200; tail = 8'd202;
        @(negedge clk); start = 0;
        for (int g = 0; g < 3000 && busy; g++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(log_n == 7, "R9", "writes from first walk only", 32'(log_n), 32'd7);
        for (int i = 0; i < log_n; i++)
            chk(log_addr[i] == 20'h0BEEF && log_data[i] == 32'hC0DE_0000 + 32'(i), "R9",
                "no stray write", log_data[i], 32'hC0DE_0000 + 32'(i));

        chk(hold_err == 0, "R8", "payload held while stalled", 32'(hold_err), 32'd0);

        // Unknown opcode.
        stall_en = 0;
        mem[160] = 32'h1111_2222;
        mem[161] = op_word(8'h01, 4'hF, 20'h00100);
        mem[162] = 32'h0;
        mem[163] = op_word(8'h05, 4'hF, 20'h00200);
        mem[164] = 32'h3333_4444;
        mem[165] = op_word(8'h01, 4'hF, 20'h00300);
        run(8'd160, 8'd166);
        chk(err == 1'b1, "R7", "err set", {31'd0, err}, 32'd1);
        chk(log_n == 1 && done_cnt == 0, "R7", "halt without done",
            {16'(log_n), 16'(done_cnt)}, {16'd1, 16'd0});
        log_n = 0;
        @(negedge clk); start = 1; head = 8'd160; tail = 8'd162;
        @(negedge clk); start = 0;
        repeat (4) @(negedge clk);
        chk(!busy && log_n == 0 && err, "R7", "start ignored while err",
            {30'd0, busy, err}, 32'd1);

        rst_n = 0;
        @(negedge clk); @(negedge clk);
        chk(!err && !busy && !done, "R1", "reset clears err", {29'd0, err, busy, done}, 32'd0);
        rst_n = 1;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule